// File: doc/BRIEF.md
# Context Region Write and Load Guard

This block sits beside a small channel-program processor whose per-channel saved contexts live at the bottom of a shared local RAM. Each channel owns a fixed slot of eight words, slot n starting at word n*8, and the slots together form a protected context region whose size is picked at run time. When the guard is switched on, it inspects each RAM write issued by the running channel program and each incoming service request that would bring in a saved context.

A write whose target lies inside the context region is refused: the RAM write enable is held low in that cycle and an abort pulse tells the core to leave the running channel. A service request whose priority number points at a slot that does not fit inside the region is refused in the same way. The first error is captured in a sticky status word (kind, instruction address, running channel); later errors only raise an overflow flag until software clears the word with a strobe. With the guard switched off, the RAM behaves as one open area.

Top module: `ctx_guard_top`

## Requirements
- R1: With `part_en` low, `abort` stays low and `ram_we` equals `wr_req` for every address and priority.
- R2: `area_sel` values 0, 1, 2, 3 select a context region of 32, 64, 128, 256 words starting at word 0; with `part_en` high, a write to an address below the region size is a violation and one at or above it is not.
- R3: A write violation holds `ram_we` low in the same cycle the write is presented.
- R4: With `part_en` high, a request with priority n (n not 0) is a violation when (n+1)*8 exceeds the region size; priority 0 means no request and never violates.
- R5: `abort` is high in exactly the cycles in which a write or a request violation is presented, combinationally from the inputs.
- R6: When `err_valid` is low (or `err_clr` is high) and an error occurs, the next clock sets `err_valid` and captures the kind, `instr_addr` and `run_chan` of that cycle; while `err_valid` is high and no clear occurs, these fields hold.
- R7: An error while `err_valid` is high and `err_clr` is low sets `err_ovf` on the next clock and leaves the captured fields unchanged.
- R8: `err_kind` is 2'b01 for a write into the region and 2'b10 for an out-of-range context load; when both happen in one cycle the captured kind is 2'b01.
- R9: `err_clr` zeroes the status word (valid, overflow, kind, address, channel) on the next clock; an error presented in the same cycle is captured as a new first error with overflow low.
- R10: After reset, `err_valid`, `err_ovf`, `err_kind`, `err_pc` and `err_chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| part_en | input | 1 | Partition checking enable |
| area_sel | input | 2 | Context region size select |
| wr_req | input | 1 | Channel program RAM write request |
| wr_addr | input | 12 | RAM word address of the write |
| instr_addr | input | 16 | Address of the instruction being executed |
| run_chan | input | 8 | Channel currently executing |
| req_prio | input | 8 | Priority number of incoming request, 0 for none |
| err_clr | input | 1 | Status clear strobe |
| ram_we | output | 1 | Gated RAM write enable |
| abort | output | 1 | Exit running channel |
| err_valid | output | 1 | Status word holds an error |
| err_ovf | output | 1 | Further errors after the first |
| err_kind | output | 2 | Kind of first error |
| err_pc | output | 16 | Instruction address of first error |
| err_chan | output | 8 | Channel of first error |

## Verification
The write check and the request check can both fire in one cycle, and either can coincide with the clear strobe. Random stimulus biases write addresses and priorities toward region boundaries so both violations often land together, and directed steps force a joint violation and a clear with a simultaneous error. A bench model decides the kind from the write-first rule and whether the clear starts a fresh capture, and the status word is compared each cycle against it.

// File: rtl/ctx_guard_pkg.sv
package ctx_guard_pkg;
    parameter int ADDR_W    = 12;
    parameter int PC_W      = 16;
    parameter int PRIO_W    = 8;
    parameter int CTX_WORDS = 8;
    parameter int BASE_AREA = 32;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_LOAD  = 2'b10
    } err_kind_e;

    typedef struct packed {
        logic              valid;
        logic              ovf;
        err_kind_e         kind;
        logic [PC_W-1:0]   pc;
        logic [PRIO_W-1:0] chan;
    } err_word_t;

    function automatic int unsigned region_words(input logic [1:0] sel);
        return BASE_AREA << sel;
    endfunction
endpackage

// File: rtl/ctx_wr_check.sv
module ctx_wr_check
    import ctx_guard_pkg::*;
(
    input  logic              part_en,
    input  logic [1:0]        area_sel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_viol,
    output logic              we_gated
);
    logic in_region;

    always_comb begin
        in_region = 32'(wr_addr) < region_words(area_sel);
        wr_viol   = part_en && wr_req && in_region;
        we_gated  = wr_req && !wr_viol;
    end

    always_comb begin
        if (wr_viol) AST_WE_SUPPRESSED: assert (!we_gated); // R3
    end
endmodule

// File: rtl/ctx_req_check.sv
module ctx_req_check
    import ctx_guard_pkg::*;
(
    input  logic              part_en,
    input  logic [1:0]        area_sel,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              req_viol
);
    logic        has_req;
    logic [31:0] slot_end;

    always_comb begin
        has_req  = req_prio != '0;
        slot_end = (32'(req_prio) + 32'd1) * 32'(CTX_WORDS);
        req_viol = part_en && has_req && (slot_end > region_words(area_sel));
    end

    always_comb begin
        if (req_prio == '0) AST_PRIO0_QUIET: assert (!req_viol); // R4
    end
endmodule

// File: rtl/ctx_err_status.sv
module ctx_err_status
    import ctx_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_viol,
    input  logic              req_viol,
    input  logic              err_clr,
    input  logic [PC_W-1:0]   instr_addr,
    input  logic [PRIO_W-1:0] run_chan,
    output err_word_t         status
);
    logic      any_err;
    logic      fresh;
    err_word_t next_word;

    always_comb begin
        any_err   = wr_viol || req_viol;
        fresh     = err_clr || !status.valid;
        next_word = status;
        if (fresh) begin
            next_word = '0;
            if (any_err) begin
                next_word.valid = 1'b1;
                next_word.kind  = wr_viol ? KIND_WRITE : KIND_LOAD;
                next_word.pc    = instr_addr;
                next_word.chan  = run_chan;
            end
        end else if (any_err) begin
            next_word.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= next_word;
    end

    AST_CAPTURE_FIRST: assert property (@(posedge clk) disable iff (rst)
        (wr_viol || req_viol) && (err_clr || !status.valid) |=> status.valid && !status.ovf); // R6
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (rst)
        status.valid && !err_clr |=> status.valid && $stable(status.kind) && $stable(status.pc)); // R6
    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        status.valid && !err_clr && (wr_viol || req_viol) |=> status.ovf); // R7
    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (rst)
        wr_viol && req_viol && (err_clr || !status.valid) |=> status.kind == KIND_WRITE); // R8
endmodule

// File: rtl/ctx_guard_top.sv
module ctx_guard_top
    import ctx_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              part_en,
    input  logic [1:0]        area_sel,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PC_W-1:0]   instr_addr,
    input  logic [PRIO_W-1:0] run_chan,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              err_clr,
    output logic              ram_we,
    output logic              abort,
    output logic              err_valid,
    output logic              err_ovf,
    output logic [1:0]        err_kind,
    output logic [PC_W-1:0]   err_pc,
    output logic [PRIO_W-1:0] err_chan
);
    logic      wr_viol;
    logic      req_viol;
    err_word_t status;

    ctx_wr_check u_wr (
        .part_en (part_en),
        .area_sel(area_sel),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_viol (wr_viol),
        .we_gated(ram_we)
    );

    ctx_req_check u_req (
        .part_en (part_en),
        .area_sel(area_sel),
        .req_prio(req_prio),
        .req_viol(req_viol)
    );

    ctx_err_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr_viol   (wr_viol),
        .req_viol  (req_viol),
        .err_clr   (err_clr),
        .instr_addr(instr_addr),
        .run_chan  (run_chan),
        .status    (status)
    );

    always_comb begin
        abort     = wr_viol || req_viol;
        err_valid = status.valid;
        err_ovf   = status.ovf;
        err_kind  = status.kind;
        err_pc    = status.pc;
        err_chan  = status.chan;
    end

    always_comb begin
        if (!part_en) AST_OFF_NO_ABORT: assert (!abort && (ram_we == wr_req)); // R1
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        err_clr && !abort |=> !err_valid && !err_ovf && err_kind == 2'b00); // R9
endmodule

// File: tb/ctx_guard_top_tb_top.sv
module ctx_guard_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        part_en;
    logic [1:0]  area_sel;
    logic        wr_req;
    logic [11:0] wr_addr;
    logic [15:0] instr_addr;
    logic [7:0]  run_chan;
    logic [7:0]  req_prio;
    logic        err_clr;
    logic        ram_we, abort, err_valid, err_ovf;
    logic [1:0]  err_kind;
    logic [15:0] err_pc;
    logic [7:0]  err_chan;

    int n_cmp = 0;
    int n_bad = 0;

    logic        m_valid, m_ovf;
    logic [1:0]  m_kind;
    logic [15:0] m_pc;
    logic [7:0]  m_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_guard_top dut_i (
        .clk(clk), .rst(rst), .part_en(part_en), .area_sel(area_sel),
        .wr_req(wr_req), .wr_addr(wr_addr), .instr_addr(instr_addr),
        .run_chan(run_chan), .req_prio(req_prio), .err_clr(err_clr),
        .ram_we(ram_we), .abort(abort), .err_valid(err_valid),
        .err_ovf(err_ovf), .err_kind(err_kind), .err_pc(err_pc),
        .err_chan(err_chan)
    );

    function automatic int size_of(input logic [1:0] s);
        return 32 * (1 << s);
    endfunction

    function automatic logic exp_wv(input logic pe, input logic [1:0] s,
                                    input logic w, input logic [11:0] a);
        return pe && w && (int'(a) < size_of(s));
    endfunction

    function automatic logic exp_rv(input logic pe, input logic [1:0] s,
                                    input logic [7:0] p);
        return pe && (p != 0) && ((int'(p) + 1) * 8 > size_of(s));
    endfunction

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_status(input string tag);
        check(tag, "status", {err_valid, err_ovf, err_kind, err_pc, err_chan},
              {m_valid, m_ovf, m_kind, m_pc, m_chan});
    endtask

    task automatic step(input string tag, input logic pe, input logic [1:0] s,
                        input logic w, input logic [11:0] a, input logic [15:0] pc,
                        input logic [7:0] ch, input logic [7:0] p, input logic clr);
        logic wv, rv;
        @(negedge clk);
        part_en = pe; area_sel = s; wr_req = w; wr_addr = a;
        instr_addr = pc; run_chan = ch; req_prio = p; err_clr = clr;
        #1;
        wv = exp_wv(pe, s, w, a);
        rv = exp_rv(pe, s, p);
        check(tag, "abort", abort, wv || rv);       // R5
        check(tag, "ram_we", ram_we, w && !wv);     // R3
        check_status(tag);                          // R6
        @(posedge clk);
        if (clr || !m_valid) begin
            {m_valid, m_ovf, m_kind, m_pc, m_chan} = '0;
            if (wv || rv) begin
                m_valid = 1'b1;
                m_kind  = wv ? 2'b01 : 2'b10;
                m_pc    = pc;
                m_chan  = ch;
            end
        end else if (wv || rv) begin
            m_ovf = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; part_en = 0; area_sel = 0; wr_req = 0; wr_addr = 0;
        instr_addr = 0; run_chan = 0; req_prio = 0; err_clr = 0;
        {m_valid, m_ovf, m_kind, m_pc, m_chan} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 check_status("R10");

        // R1: disabled, writes into region and far priorities pass
        step("R1", 0, 0, 1, 12'd0, 16'h11, 8'd1, 8'd200, 0);
        // R2: boundaries of each region size
        for (int s = 0; s < 4; s++) begin
            step("R2", 1, 2'(s), 1, 12'(size_of(2'(s)) - 1), 16'h100, 8'd2, 8'd0, 1);
            step("R2", 1, 2'(s), 1, 12'(size_of(2'(s))),     16'h101, 8'd2, 8'd0, 1);
        end
        // R4: last slot that fits and first that does not, plus priority 0
        step("R4", 1, 2'd0, 0, 12'd0, 16'h200, 8'd3, 8'd3, 1);
        step("R4", 1, 2'd0, 0, 12'd0, 16'h201, 8'd3, 8'd4, 1);
        step("R4", 1, 2'd3, 0, 12'd0, 16'h202, 8'd3, 8'd31, 1);
        step("R4", 1, 2'd3, 0, 12'd0, 16'h203, 8'd3, 8'd32, 1);
        step("R4", 1, 2'd0, 0, 12'd0, 16'h204, 8'd3, 8'd0, 1);
        // R8: both violations in one cycle, write kind wins
        step("R8", 1, 2'd1, 1, 12'd5, 16'h300, 8'd7, 8'd9, 1);
        // R7: second error only raises overflow
        step("R7", 1, 2'd1, 0, 12'd0, 16'h301, 8'd8, 8'd9, 0);
        step("R7", 1, 2'd1, 0, 12'd0, 16'h302, 8'd8, 8'd0, 0);
        // R9: clear with simultaneous error, then plain clear
        step("R9", 1, 2'd1, 0, 12'd0, 16'h400, 8'd4, 8'd20, 1);
        step("R9", 1, 2'd1, 0, 12'd0, 16'h401, 8'd4, 8'd0, 1);
        step("R9", 1, 2'd1, 0, 12'd0, 16'h402, 8'd4, 8'd0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic [7:0]  p;
            a = ($urandom % 2) ? 12'($urandom % 300) : 12'($urandom);
            p = ($urandom % 5 < 2) ? 8'd0 : 8'($urandom % 40);
            step("RND", ($urandom % 8) != 0, 2'($urandom), 1'($urandom),
                 a, 16'($urandom), 8'($urandom), p, ($urandom % 20) == 0);
        end

        @(negedge clk); #1 check_status("R6");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule